// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Sequencer

This block stands between a command interface and an array of one-time-programmable fuse words. It produces the timed sense and program strobes that the fuse array needs. It also keeps a shadow copy of every fuse word, which can be read at any time through a combinational read port. Four timing fields are supplied as inputs: a read setup count, a relax count, a read strobe count and a program strobe count. From these the sequencer builds a setup phase, a leading relax phase, the active pulse and a trailing relax phase, all counted in clock cycles.

Two commands exist. A program command ORs a data word into one fuse word and then merges the same data into that word's shadow copy. A reload command senses every fuse word in ascending order and refreshes the whole shadow bank without a reset. The sequencer raises a busy flag while a command runs. A sticky error flag records rejected commands: a program to a locked or out-of-range word, or any command issued while the sequencer is busy. Software clears the error flag with a write-one-to-clear pulse.

Top module: `fuse_seq`

## Requirements
- R1: After reset, busy, error, fuse_rden and fuse_pgm are low and every shadow word reads zero.
- R2: An accepted reload holds fuse_rden low for (tim_wait+1)+(tim_relax+1) busy cycles before the first sense pulse. An accepted program holds fuse_pgm low for 2·(tim_relax+1) busy cycles before the program pulse.
- R3: Each sense pulse on fuse_rden lasts (tim_strb_rd+1) − 2·(tim_relax+1) cycles when that value is positive.
- R4: Each program pulse on fuse_pgm lasts (tim_strb_pg+1) − 2·(tim_relax+1) cycles when that value is positive, and presents the command's address on fuse_addr and its data on fuse_wdata.
- R5: When a strobe count minus twice the relax interval is zero or negative, the pulse lasts exactly one cycle.
- R6: busy is high for the whole operation and falls after a single finishing cycle that follows the trailing relax phase. A program keeps busy high for 3·(tim_relax+1)+P+1 cycles. A reload keeps it high for WORDS·((tim_wait+1)+2·(tim_relax+1)+P+1) cycles, where P is the pulse length.
- R7: A reload (cmd_prog=0) senses words 0 to WORDS−1 in ascending order and stores each sensed value in its shadow word. fuse_addr stays steady during each pulse.
- R8: When a program (cmd_prog=1) completes, its shadow word equals the previous shadow value ORed with the command data. The rest of the shadow bank is unchanged.
- R9: A program to a word whose lock_mask bit is set, or to an address of WORDS or more, produces no program strobe and does not raise busy, and error is high on the next cycle.
- R10: A command presented while busy is high is dropped and sets error. The running operation completes unchanged.
- R11: error stays high until a cycle with err_clr high. If a new error event occurs in the same cycle as err_clr, error stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_wait | input | TW | Read setup count (setup lasts value+1 cycles) |
| tim_relax | input | TW | Relax count (each relax phase lasts value+1 cycles) |
| tim_strb_rd | input | TW | Total read strobe window count |
| tim_strb_pg | input | TW | Total program strobe window count |
| cmd_valid | input | 1 | Command request, one cycle |
| cmd_prog | input | 1 | 1 = program, 0 = reload all shadow words |
| cmd_addr | input | AW | Word address for a program |
| cmd_data | input | DW | Data to OR into the fuse word |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| lock_mask | input | WORDS | One lock bit per word; set bit blocks programming |
| busy | output | 1 | Operation in progress |
| error | output | 1 | Sticky error flag |
| shd_raddr | input | AW | Shadow read address |
| shd_rdata | output | DW | Shadow word at shd_raddr |
| fuse_addr | output | AW | Fuse word address |
| fuse_rden | output | 1 | Fuse sense pulse |
| fuse_pgm | output | 1 | Fuse program pulse |
| fuse_wdata | output | DW | Program data to the fuse array |
| fuse_rdata | input | DW | Sensed fuse word, valid while fuse_rden is high |

## Verification
The hardest case to reach is a command that arrives in the middle of a long reload, in the same cycle as an error clear. The reject event and the clear then collide while the sequencer must leave the running sweep untouched. The stimulus starts a reload and waits a few cycles. It then drives a program request and err_clr together, and checks that error stays set, that no program strobe appears and that the reload's busy length and shadow contents come out as predicted. Timing settings with negative and exactly zero net pulse widths drive the one-cycle clamp for both strobe kinds.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RLX_A,
    ST_PULSE,
    ST_RLX_B,
    ST_FINISH
  } seq_state_e;

  // A count field of N means N+1 cycles.
  function automatic int unsigned span_cycles(input int unsigned field);
    return field + 32'd1;
  endfunction

  // Net pulse: strobe window minus two relax intervals, at least one cycle.
  function automatic int unsigned pulse_cycles(input int unsigned strobe,
                                               input int unsigned relax);
    int unsigned win;
    int unsigned frame;
    win   = strobe + 32'd1;
    frame = 32'd2 * (relax + 32'd1);
    return (win > frame) ? (win - frame) : 32'd1;
  endfunction

endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_len,
  output logic          last
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_len - ONE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign last = (cnt_q == '0);

  // R5: a phase is never loaded with zero length
  a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (ld_len != '0));

endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          or_mode,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          hit;
    assign hit = we && (wr_idx == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        word_q <= or_mode ? (word_q | wr_data) : wr_data;
      end
    end
    assign words[g] = word_q;
  end

  assign rd_data = words[rd_idx];

  // R8: after a merge write every data bit is present in the word
  a_r8_merge_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we && or_mode) |=> ((words[$past(wr_idx)] & $past(wr_data)) == $past(wr_data)));

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int TW    = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW   = TW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tim_wait,
  input  logic [TW-1:0]    tim_relax,
  input  logic [TW-1:0]    tim_strb_rd,
  input  logic [TW-1:0]    tim_strb_pg,
  input  logic             cmd_valid,
  input  logic             cmd_prog,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  input  logic             err_clr,
  input  logic [WORDS-1:0] lock_mask,
  output logic             busy,
  output logic             error,
  output logic [AW-1:0]    fuse_addr,
  output logic             fuse_rden,
  output logic             fuse_pgm,
  output logic [DW-1:0]    fuse_wdata,
  input  logic [DW-1:0]    fuse_rdata,
  output logic             t_ld,
  output logic [CW-1:0]    t_len,
  input  logic             t_last,
  output logic             sh_we,
  output logic             sh_or,
  output logic [AW-1:0]    sh_idx,
  output logic [DW-1:0]    sh_wdata
);

  localparam logic [AW:0]   WORDS_W  = (AW+1)'(WORDS);
  localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);
  localparam logic [AW-1:0] ONE_IDX  = AW'(1);

  seq_state_e    state_q;
  logic          op_prog_q;
  logic [AW-1:0] cur_addr_q;
  logic [DW-1:0] op_data_q;
  logic [CW-1:0] lat_setup_q;
  logic [CW-1:0] lat_relax_q;
  logic [CW-1:0] lat_pulse_q;

  // Lengths computed from the live timing fields
  logic [CW-1:0] len_wait;
  logic [CW-1:0] len_relax;
  logic [CW-1:0] len_pulse_rd;
  logic [CW-1:0] len_pulse_pg;

  assign len_wait     = CW'(span_cycles(32'(tim_wait)));
  assign len_relax    = CW'(span_cycles(32'(tim_relax)));
  assign len_pulse_rd = CW'(pulse_cycles(32'(tim_strb_rd), 32'(tim_relax)));
  assign len_pulse_pg = CW'(pulse_cycles(32'(tim_strb_pg), 32'(tim_relax)));

  // Named events
  logic idle;
  logic addr_ok;
  logic prog_blocked;
  logic ev_accept;
  logic ev_lock_reject;
  logic ev_busy_drop;
  logic sweep_more;
  logic ev_capture;
  logic ev_commit;

  assign idle           = (state_q == ST_IDLE);
  assign addr_ok        = ({1'b0, cmd_addr} < WORDS_W);
  assign prog_blocked   = cmd_prog && (!addr_ok || lock_mask[cmd_addr]);
  assign ev_accept      = idle && cmd_valid && !prog_blocked;
  assign ev_lock_reject = idle && cmd_valid && prog_blocked;
  assign ev_busy_drop   = !idle && cmd_valid;
  assign sweep_more     = !op_prog_q && (cur_addr_q != LAST_IDX);
  assign ev_capture     = (state_q == ST_PULSE) && t_last && !op_prog_q;
  assign ev_commit      = (state_q == ST_FINISH) && op_prog_q;

  // Phase timer loading
  always_comb begin
    t_ld  = 1'b0;
    t_len = lat_relax_q;
    unique case (state_q)
      ST_IDLE: begin
        t_ld  = ev_accept;
        t_len = cmd_prog ? len_relax : len_wait;
      end
      ST_SETUP: begin
        t_ld  = t_last;
        t_len = lat_relax_q;
      end
      ST_RLX_A: begin
        t_ld  = t_last;
        t_len = lat_pulse_q;
      end
      ST_PULSE: begin
        t_ld  = t_last;
        t_len = lat_relax_q;
      end
      ST_RLX_B: begin
        t_ld  = 1'b0;
        t_len = lat_relax_q;
      end
      ST_FINISH: begin
        t_ld  = sweep_more;
        t_len = lat_setup_q;
      end
      default: begin
        t_ld  = 1'b0;
        t_len = lat_relax_q;
      end
    endcase
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_prog_q   <= 1'b0;
      cur_addr_q  <= '0;
      op_data_q   <= '0;
      lat_setup_q <= '0;
      lat_relax_q <= '0;
      lat_pulse_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            state_q     <= ST_SETUP;
            op_prog_q   <= cmd_prog;
            cur_addr_q  <= cmd_prog ? cmd_addr : '0;
            op_data_q   <= cmd_data;
            lat_setup_q <= cmd_prog ? len_relax : len_wait;
            lat_relax_q <= len_relax;
            lat_pulse_q <= cmd_prog ? len_pulse_pg : len_pulse_rd;
          end
        end
        ST_SETUP: if (t_last) state_q <= ST_RLX_A;
        ST_RLX_A: if (t_last) state_q <= ST_PULSE;
        ST_PULSE: if (t_last) state_q <= ST_RLX_B;
        ST_RLX_B: if (t_last) state_q <= ST_FINISH;
        ST_FINISH: begin
          if (sweep_more) begin
            cur_addr_q <= cur_addr_q + ONE_IDX;
            state_q    <= ST_SETUP;
          end else begin
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Sticky error, a new event wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error <= 1'b0;
    end else if (ev_busy_drop || ev_lock_reject) begin
      error <= 1'b1;
    end else if (err_clr) begin
      error <= 1'b0;
    end
  end

  assign busy       = !idle;
  assign fuse_addr  = cur_addr_q;
  assign fuse_rden  = (state_q == ST_PULSE) && !op_prog_q;
  assign fuse_pgm   = (state_q == ST_PULSE) && op_prog_q;
  assign fuse_wdata = op_prog_q ? op_data_q : '0;

  assign sh_we    = ev_capture || ev_commit;
  assign sh_or    = op_prog_q;
  assign sh_idx   = cur_addr_q;
  assign sh_wdata = op_prog_q ? op_data_q : fuse_rdata;

  // R9: a blocked program leaves the sequencer idle with error set
  a_r9_lock_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_prog && lock_mask[cmd_addr]) |=> (!busy && error));

  // R10: a command while busy sets error
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> error);

  // R11: error holds without a clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !err_clr) |=> error);

  // R11: a clear with no competing command drops error
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !cmd_valid) |=> !error);

  // R6: busy only falls out of the finishing cycle
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (state_q != ST_FINISH)) |=> busy);

  // R7: address steady across a sense pulse
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rden |=> (!fuse_rden || $stable(fuse_addr)));

  // R4: data steady across a program pulse
  a_r4_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_pgm |=> (!fuse_pgm || ($stable(fuse_wdata) && $stable(fuse_addr))));

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int TW    = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW   = TW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tim_wait,
  input  logic [TW-1:0]    tim_relax,
  input  logic [TW-1:0]    tim_strb_rd,
  input  logic [TW-1:0]    tim_strb_pg,
  input  logic             cmd_valid,
  input  logic             cmd_prog,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  input  logic             err_clr,
  input  logic [WORDS-1:0] lock_mask,
  output logic             busy,
  output logic             error,
  input  logic [AW-1:0]    shd_raddr,
  output logic [DW-1:0]    shd_rdata,
  output logic [AW-1:0]    fuse_addr,
  output logic             fuse_rden,
  output logic             fuse_pgm,
  output logic [DW-1:0]    fuse_wdata,
  input  logic [DW-1:0]    fuse_rdata
);

  logic          t_ld;
  logic [CW-1:0] t_len;
  logic          t_last;
  logic          sh_we;
  logic          sh_or;
  logic [AW-1:0] sh_idx;
  logic [DW-1:0] sh_wdata;

  fuse_seq_ctrl #(.WORDS(WORDS), .DW(DW), .TW(TW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tim_wait   (tim_wait),
    .tim_relax  (tim_relax),
    .tim_strb_rd(tim_strb_rd),
    .tim_strb_pg(tim_strb_pg),
    .cmd_valid  (cmd_valid),
    .cmd_prog   (cmd_prog),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .err_clr    (err_clr),
    .lock_mask  (lock_mask),
    .busy       (busy),
    .error      (error),
    .fuse_addr  (fuse_addr),
    .fuse_rden  (fuse_rden),
    .fuse_pgm   (fuse_pgm),
    .fuse_wdata (fuse_wdata),
    .fuse_rdata (fuse_rdata),
    .t_ld       (t_ld),
    .t_len      (t_len),
    .t_last     (t_last),
    .sh_we      (sh_we),
    .sh_or      (sh_or),
    .sh_idx     (sh_idx),
    .sh_wdata   (sh_wdata)
  );

  fuse_phase_timer #(.CW(CW)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (t_ld),
    .ld_len(t_len),
    .last  (t_last)
  );

  fuse_shadow_bank #(.WORDS(WORDS), .DW(DW)) bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (sh_we),
    .or_mode(sh_or),
    .wr_idx (sh_idx),
    .wr_data(sh_wdata),
    .rd_idx (shd_raddr),
    .rd_data(shd_rdata)
  );

endmodule

// File: tb/fuse_seq_tb.sv
`timescale 1ns/1ps
module fuse_seq_tb_top;

  localparam int WORDS = 8;
  localparam int DW    = 32;
  localparam int TW    = 8;
  localparam int AW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TW-1:0]    tim_wait = '0, tim_relax = '0, tim_strb_rd = '0, tim_strb_pg = '0;
  logic             cmd_valid = 1'b0, cmd_prog = 1'b0, err_clr = 1'b0;
  logic [AW-1:0]    cmd_addr = '0, shd_raddr = '0;
  logic [DW-1:0]    cmd_data = '0;
  logic [WORDS-1:0] lock_mask = '0;
  logic             busy, error, fuse_rden, fuse_pgm;
  logic [DW-1:0]    shd_rdata, fuse_wdata, fuse_rdata;
  logic [AW-1:0]    fuse_addr;

  always #2.5 clk = ~clk;

  fuse_seq #(.WORDS(WORDS), .DW(DW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tim_wait(tim_wait), .tim_relax(tim_relax),
    .tim_strb_rd(tim_strb_rd), .tim_strb_pg(tim_strb_pg),
    .cmd_valid(cmd_valid), .cmd_prog(cmd_prog), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .err_clr(err_clr), .lock_mask(lock_mask),
    .busy(busy), .error(error), .shd_raddr(shd_raddr), .shd_rdata(shd_rdata),
    .fuse_addr(fuse_addr), .fuse_rden(fuse_rden), .fuse_pgm(fuse_pgm),
    .fuse_wdata(fuse_wdata), .fuse_rdata(fuse_rdata)
  );

  // Behavioural fuse array
  logic [DW-1:0] fuse_arr [WORDS];
  assign fuse_rdata = fuse_rden ? fuse_arr[fuse_addr] : '0;
  always @(posedge clk) if (fuse_pgm) fuse_arr[fuse_addr] <= fuse_arr[fuse_addr] | fuse_wdata;

  function automatic logic [DW-1:0] init_word(int i);
    return (32'h0102_0304 * i) ^ 32'h00A0_0005;
  endfunction

  // Expected model
  logic [DW-1:0] exp_fuse [WORDS];
  logic [DW-1:0] exp_shadow [WORDS];

  int checks = 0;
  int failures = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int net_pulse(int strobe, int relax);
    int t;
    t = (strobe + 1) - 2 * (relax + 1);
    return (t < 1) ? 1 : t;
  endfunction

  // Scoreboard queues
  int    q_rd_len[$];   string q_rd_tag[$];  int q_rd_addr[$];
  int    q_pg_len[$];   string q_pg_tag[$];  int q_pg_addr[$];
  logic [DW-1:0] q_pg_data[$];
  int    q_gap[$];
  int    q_busy[$];

  // Monitor
  int rd_run = 0, pg_run = 0, busy_run = 0, gap_cnt = 0;
  bit seen_strobe = 0;
  string cur_rd_tag = "R3", cur_pg_tag = "R4";

  always @(negedge clk) begin
    if (rst_n) begin
      if (fuse_rden) begin
        if (rd_run == 0) begin
          if (q_rd_addr.size() == 0) begin
            checks++; failures++;
            $display("FAIL R7 unexpected sense pulse act=%0d exp=none", fuse_addr);
          end else begin
            chk("R7 sweep order", 32'(fuse_addr), 32'(q_rd_addr.pop_front()));
          end
        end
        rd_run++;
      end else if (rd_run > 0) begin
        if (q_rd_len.size() == 0) begin
          checks++; failures++;
          $display("FAIL R3 unexpected sense width act=%0d exp=none", rd_run);
        end else begin
          cur_rd_tag = q_rd_tag.pop_front();
          chk(cur_rd_tag, 32'(rd_run), 32'(q_rd_len.pop_front()));
        end
        rd_run = 0;
      end

      if (fuse_pgm) begin
        if (pg_run == 0) begin
          if (q_pg_addr.size() == 0) begin
            checks++; failures++;
            $display("FAIL R9 R10 unexpected program pulse act=%0d exp=none", fuse_addr);
          end else begin
            chk("R4 program address", 32'(fuse_addr), 32'(q_pg_addr.pop_front()));
            chk("R4 program data", fuse_wdata, q_pg_data.pop_front());
          end
        end
        pg_run++;
      end else if (pg_run > 0) begin
        if (q_pg_len.size() == 0) begin
          checks++; failures++;
          $display("FAIL R4 unexpected program width act=%0d exp=none", pg_run);
        end else begin
          cur_pg_tag = q_pg_tag.pop_front();
          chk(cur_pg_tag, 32'(pg_run), 32'(q_pg_len.pop_front()));
        end
        pg_run = 0;
      end

      if (busy) begin
        busy_run++;
        if (!seen_strobe) begin
          if (fuse_rden || fuse_pgm) begin
            seen_strobe = 1;
            if (q_gap.size() == 0) begin
              checks++; failures++;
              $display("FAIL R2 unexpected setup act=%0d exp=none", gap_cnt);
            end else begin
              chk("R2 setup before strobe", 32'(gap_cnt), 32'(q_gap.pop_front()));
            end
          end else begin
            gap_cnt++;
          end
        end
      end else if (busy_run > 0) begin
        if (q_busy.size() == 0) begin
          checks++; failures++;
          $display("FAIL R6 unexpected busy window act=%0d exp=none", busy_run);
        end else begin
          chk("R6 busy length", 32'(busy_run), 32'(q_busy.pop_front()));
        end
        busy_run = 0; gap_cnt = 0; seen_strobe = 0;
      end
    end
  end

  // Driver
  task automatic drive_cmd(bit prog, int addr, logic [DW-1:0] data, bit clr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_prog = prog; cmd_addr = AW'(addr);
    cmd_data = data; err_clr = clr;
    @(negedge clk);
    cmd_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic set_timing(int w, int r, int srd, int spg);
    tim_wait = TW'(w); tim_relax = TW'(r);
    tim_strb_rd = TW'(srd); tim_strb_pg = TW'(spg);
  endtask

  task automatic issue(bit prog, int addr, logic [DW-1:0] data);
    int w, r, p;
    string tag;
    w = int'(tim_wait); r = int'(tim_relax);
    if (prog) begin
      p = net_pulse(int'(tim_strb_pg), r);
      tag = ((int'(tim_strb_pg) + 1 - 2 * (r + 1)) < 1) ? "R5 program clamp" : "R4 program width";
      q_pg_len.push_back(p); q_pg_tag.push_back(tag);
      q_pg_addr.push_back(addr); q_pg_data.push_back(data);
      q_gap.push_back(2 * (r + 1));
      q_busy.push_back(3 * (r + 1) + p + 1);
      exp_fuse[addr]   = exp_fuse[addr] | data;
      exp_shadow[addr] = exp_shadow[addr] | data;
    end else begin
      p = net_pulse(int'(tim_strb_rd), r);
      tag = ((int'(tim_strb_rd) + 1 - 2 * (r + 1)) < 1) ? "R5 sense clamp" : "R3 sense width";
      for (int i = 0; i < WORDS; i++) begin
        q_rd_len.push_back(p); q_rd_tag.push_back(tag); q_rd_addr.push_back(i);
        exp_shadow[i] = exp_fuse[i];
      end
      q_gap.push_back((w + 1) + (r + 1));
      q_busy.push_back(WORDS * ((w + 1) + 2 * (r + 1) + p + 1));
    end
    drive_cmd(prog, addr, data, 1'b0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic check_shadow(string req);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      shd_raddr = AW'(i);
      #1;
      chk(req, shd_rdata, exp_shadow[i]);
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R6 watchdog act=busy exp=idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      fuse_arr[i]   = init_word(i);
      exp_fuse[i]   = init_word(i);
      exp_shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 error", 32'(error), 0);
    chk("R1 sense strobe", 32'(fuse_rden), 0);
    chk("R1 program strobe", 32'(fuse_pgm), 0);
    check_shadow("R1 shadow zero");

    // Config A: read pulse 7, program pulse 17
    set_timing(3, 1, 10, 20);
    issue(1'b1, 3, 32'h0000_F00F);       // R8 merge into zero shadow
    wait_idle();
    check_shadow("R8 merge before reload");

    issue(1'b0, 0, '0);                  // R7 reload sweep
    wait_idle();
    check_shadow("R7 reload contents");

    issue(1'b1, 3, 32'h0F00_0000);
    wait_idle();
    check_shadow("R8 merge after reload");

    // R9 locked word and out-of-lock bounds
    lock_mask = 8'b0010_0000;
    drive_cmd(1'b1, 5, 32'hFFFF_FFFF, 1'b0);
    chk("R9 busy stays low", 32'(busy), 0);
    chk("R9 error set", 32'(error), 1);
    repeat (4) @(negedge clk);
    chk("R11 error sticky", 32'(error), 1);
    check_shadow("R9 shadow untouched");
    drive_cmd(1'b0, 0, '0, 1'b1);       // err_clr alone, cmd_valid with reload
    wait_idle();
    // that reload was accepted, push its expectations after the fact is not possible,
    // so clear is tested separately below
    lock_mask = '0;

    // Config B: both pulses clamp to one cycle
    set_timing(0, 2, 3, 5);
    issue(1'b0, 0, '0);
    wait_idle();
    issue(1'b1, 1, 32'h8000_0001);
    wait_idle();
    check_shadow("R5 shadow after clamped ops");

    // Config C: read pulse 5, program pulse 2
    set_timing(5, 0, 6, 3);
    issue(1'b1, 6, 32'h0000_0C00);
    wait_idle();
    issue(1'b0, 0, '0);
    repeat (3) @(negedge clk);
    drive_cmd(1'b1, 2, 32'hFFFF_0000, 1'b1);   // R10 drop, R11 set wins over clear
    chk("R10 error on busy command", 32'(error), 1);
    chk("R11 set wins over clear", 32'(error), 1);
    wait_idle();
    chk("R10 error held after sweep", 32'(error), 1);
    check_shadow("R10 sweep unaffected");

    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R11 clear", 32'(error), 0);

    for (int i = 0; i < WORDS; i++) chk("R4 fuse contents", fuse_arr[i], exp_fuse[i]);
    chk("R6 scoreboard drained", 32'(q_busy.size() + q_rd_len.size() + q_pg_len.size()), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Expectations for the reload accepted together with the first error clear
  initial begin
    wait (lock_mask == 8'b0010_0000);
    @(posedge cmd_valid iff (err_clr == 1'b1));
    for (int i = 0; i < WORDS; i++) begin
      q_rd_len.push_back(net_pulse(10, 1)); q_rd_tag.push_back("R3 sense width");
      q_rd_addr.push_back(i);
    end
    q_gap.push_back(4 + 2);
    q_busy.push_back(WORDS * (4 + 4 + net_pulse(10, 1) + 1));
    @(negedge clk);
    @(negedge clk);
    chk("R11 clear with accepted command", 32'(error), 0);
  end

endmodule